// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block lets a host run PHY management transfers through two small registers. The host writes the transfer data into the data register, then writes the command register with an operation code, a PHY address, a register address and the start bit. The block shifts out a complete Clause 22 frame on the management clock and data lines. It drops the start bit, which also serves as the busy flag, when the last bit has gone out. After a read, the data register holds the word that the PHY returned.

The management clock comes from the core clock, divided by a ratio chosen with a small encoded clock-range field. The host picks the code that matches its core-clock band. Codes 2, 3, 0, 1 and 4 cover 20–35, 35–60, 60–100, 100–150 and 150–250 MHz. The data line is split into an output, an output enable and an input, so the pad logic can build the tri-state buffer.

Top module: `mgmt_c22_master`

## Requirements
- R1: After reset, both registers read zero, MDC is low and the output enable is low. The command register (reg_addr 0) reads back busy at bit 0, operation valid at bit 1, read select at bit 2, clock range at bits 5:3, register address at bits 10:6 and PHY address at bits 15:11. The data register (reg_addr 1) uses bits 15:0.
- R2: Writing bit 0 as 1 with bit 1 as 1 while idle starts a frame. The busy bit stays 1 from the cycle after the write until the frame's final MDC period ends, then reads 0.
- R3: A frame has 64 bits, sent MSB first: 32 ones, then 0 and 1, then the operation bits (01 to write, 10 to read), the 5-bit PHY address, the 5-bit register address, two turnaround bits and 16 data bits.
- R4: On a write, the master drives the turnaround as 1 then 0 and drives the data register contents. On a read, the output enable is low for both turnaround bits and for all 16 data bits.
- R5: Within a frame, the data output changes only in the cycle in which MDC has just fallen. The first bit is presented with MDC low.
- R6: On a read, the bit on mdio_in is sampled as MDC rises, during each of the 16 data bits. The word is loaded into the data register in the cycle the busy bit clears.
- R7: Clock-range codes 0, 1, 2, 3, 4 and 5 give MDC periods of 42, 62, 16, 26, 102 and 124 core cycles, high for the second half of each period. Codes 6 and 7 give 42.
- R8: While the busy bit is 0, MDC is low and the output enable is low.
- R9: While busy, writes to the data register and to every command field other than the clock range have no effect. A new clock range reads back at once but does not change the running frame's MDC period.
- R10: Writing bit 0 as 1 with bit 1 as 0 sends no frame. The busy bit reads 1 for one cycle and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data input from the pad |

## Verification
The assertions check on every cycle that the lines stay quiet while the block is idle, and that data moves only on a falling MDC edge. They also check that a frame runs only while the busy bit is set, that a bad operation code clears busy one cycle later, and that data-register writes during a transfer are dropped. The exact bit pattern of each frame, the MDC period chosen by each clock-range code, and the read word returned after completion are shown only by the bench. It compares these against its own cycle model under several operations, addresses and codes. The bench also shows that a clock-range write made during a frame reads back at once but leaves that frame's timing unchanged.

// File: rtl/mgmt_c22_pkg.sv
package mgmt_c22_pkg;

    localparam int REG_W      = 16;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int CR_W       = 3;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int IDX_TA     = FRAME_BITS - DATA_W - 2;
    localparam int IDX_DATA   = FRAME_BITS - DATA_W;
    localparam int HALF_W     = 7;

    // Command register image, MSB first
    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [CR_W-1:0]   cr;
        logic              rd;
        logic              valid;
        logic              go;
    } cmd_t;

    typedef enum logic {SH_IDLE, SH_RUN} sh_state_t;

    // Half of the MDC period in core cycles for a clock-range code
    function automatic logic [HALF_W-1:0] cr_half(input logic [CR_W-1:0] code);
        case (code)
            3'd0:    return HALF_W'(21);
            3'd1:    return HALF_W'(31);
            3'd2:    return HALF_W'(8);
            3'd3:    return HALF_W'(13);
            3'd4:    return HALF_W'(51);
            3'd5:    return HALF_W'(62);
            default: return HALF_W'(21);
        endcase
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0]        opc;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        opc = rd ? 2'b10 : 2'b01;
        ta  = rd ? 2'b00 : 2'b10;
        dat = rd ? '0 : wd;
        return {{PRE_BITS{1'b1}}, 2'b01, opc, phy, regad, ta, dat};
    endfunction

endpackage

// File: rtl/mgmt_c22_mdc_gen.sv
module mgmt_c22_mdc_gen
    import mgmt_c22_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise_evt,
    output logic              fall_evt
);

    logic [HALF_W-1:0] cnt_q;
    logic              mdc_q;
    logic              tick;

    assign tick     = run && (cnt_q == half - HALF_W'(1));
    assign rise_evt = tick && !mdc_q;
    assign fall_evt = tick && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

endmodule

// File: rtl/mgmt_c22_shifter.sv
module mgmt_c22_shifter
    import mgmt_c22_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_in,
    output logic              active,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_word
);

    sh_state_t             state_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  rd_q;
    logic [DATA_W-1:0]     cap_q;
    logic                  last_bit;
    logic                  released;

    assign active   = (state_q == SH_RUN);
    assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
    assign done     = active && fall_evt && last_bit;
    assign released = rd_q && (idx_q >= IDX_W'(IDX_TA));
    assign mdio_oe  = active && !released;
    assign mdio_o   = active && frame_q[FRAME_BITS-1];
    assign rd_word  = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            frame_q <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
        end else if (!active) begin
            if (start) begin
                state_q <= SH_RUN;
                frame_q <= build_frame(rd, phy, regad, wdata);
                idx_q   <= '0;
                rd_q    <= rd;
            end
        end else begin
            if (rise_evt && rd_q && (idx_q >= IDX_W'(IDX_DATA)))
                cap_q <= {cap_q[DATA_W-2:0], mdio_in};
            if (fall_evt) begin
                if (last_bit) begin
                    state_q <= SH_IDLE;
                    rd_q    <= 1'b0;
                end else begin
                    idx_q   <= idx_q + IDX_W'(1);
                    frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/mgmt_c22_regs.sv
module mgmt_c22_regs
    import mgmt_c22_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              frm_active,
    input  logic              frm_done,
    input  logic [DATA_W-1:0] rd_word,
    output logic              go,
    output logic              busy,
    output logic              rd,
    output logic [ADDR_W-1:0] phy,
    output logic [ADDR_W-1:0] regad,
    output logic [CR_W-1:0]   cr_act,
    output logic [DATA_W-1:0] data_val
);

    cmd_t              wcmd;
    logic              cmd_wr;
    logic              dat_wr;
    logic              busy_q;
    logic              go_q;
    logic              valid_q;
    logic              rd_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] regad_q;
    logic [CR_W-1:0]   cr_q;
    logic [CR_W-1:0]   cr_act_q;
    logic [DATA_W-1:0] data_q;
    cmd_t              rcmd;

    assign wcmd   = cmd_t'(reg_wdata);
    assign cmd_wr = reg_wr && !reg_addr;
    assign dat_wr = reg_wr && reg_addr;

    always_comb begin
        rcmd.phy   = phy_q;
        rcmd.regad = regad_q;
        rcmd.cr    = cr_q;
        rcmd.rd    = rd_q;
        rcmd.valid = valid_q;
        rcmd.go    = busy_q;
        reg_rdata  = reg_addr ? REG_W'(data_q) : REG_W'(rcmd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            go_q     <= 1'b0;
            valid_q  <= 1'b0;
            rd_q     <= 1'b0;
            phy_q    <= '0;
            regad_q  <= '0;
            cr_q     <= '0;
            cr_act_q <= '0;
            data_q   <= '0;
        end else begin
            go_q <= 1'b0;
            if (cmd_wr)
                cr_q <= wcmd.cr;
            if (!busy_q) begin
                if (cmd_wr) begin
                    valid_q  <= wcmd.valid;
                    rd_q     <= wcmd.rd;
                    phy_q    <= wcmd.phy;
                    regad_q  <= wcmd.regad;
                    busy_q   <= wcmd.go;
                    go_q     <= wcmd.go && wcmd.valid;
                    cr_act_q <= wcmd.cr;
                end else begin
                    cr_act_q <= cr_q;
                end
                if (dat_wr)
                    data_q <= reg_wdata;
            end else if (frm_done) begin
                busy_q <= 1'b0;
                if (rd_q)
                    data_q <= rd_word;
            end else if (!go_q && !frm_active) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign go       = go_q;
    assign busy     = busy_q;
    assign rd       = rd_q;
    assign phy      = phy_q;
    assign regad    = regad_q;
    assign cr_act   = cr_act_q;
    assign data_val = data_q;

endmodule

// File: rtl/mgmt_c22_master.sv
module mgmt_c22_master
    import mgmt_c22_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_in
);

    logic              go;
    logic              busy;
    logic              cmd_rd;
    logic [ADDR_W-1:0] cmd_phy;
    logic [ADDR_W-1:0] cmd_regad;
    logic [CR_W-1:0]   cr_act;
    logic [DATA_W-1:0] data_val;
    logic [DATA_W-1:0] rd_word;
    logic              frm_active;
    logic              frm_done;
    logic              rise_evt;
    logic              fall_evt;

    mgmt_c22_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .frm_active (frm_active),
        .frm_done   (frm_done),
        .rd_word    (rd_word),
        .go         (go),
        .busy       (busy),
        .rd         (cmd_rd),
        .phy        (cmd_phy),
        .regad      (cmd_regad),
        .cr_act     (cr_act),
        .data_val   (data_val)
    );

    mgmt_c22_mdc_gen u_mdc (
        .clk      (clk),
        .rst      (rst),
        .run      (frm_active),
        .half     (cr_half(cr_act)),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mgmt_c22_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (go),
        .rd       (cmd_rd),
        .phy      (cmd_phy),
        .regad    (cmd_regad),
        .wdata    (data_val),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_in  (mdio_in),
        .active   (frm_active),
        .done     (frm_done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_word  (rd_word)
    );

endmodule

// File: rtl/mgmt_c22_checker.sv
module mgmt_c22_checker
    import mgmt_c22_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [1:0]        go_bits,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              active,
    input logic              done,
    input logic [DATA_W-1:0] data_val
);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_frame_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> busy);

    assert_shift_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc)));

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && !reg_addr && go_bits[0] && !go_bits[1]) |=> busy ##1 !busy);

    assert_data_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr && !done) |=> $stable(data_val));

endmodule

bind mgmt_c22_master mgmt_c22_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .go_bits  (reg_wdata[1:0]),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .active   (frm_active),
    .done     (frm_done),
    .data_val (data_val)
);

// File: tb/mgmt_c22_master_tb.sv
`timescale 1ns/1ps
module mgmt_c22_master_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    mgmt_c22_master u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0: return 42;
            1: return 62;
            2: return 16;
            3: return 26;
            4: return 102;
            5: return 124;
            default: return 42;
        endcase
    endfunction

    // Reference model state
    bit          m_run = 0;
    bit          m_valid, m_rd;
    int          m_t, m_end, m_n;
    bit [63:0]   m_frame;
    logic [15:0] m_data = '0;
    logic [15:0] phy_resp = '0;
    bit          was_idle;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_t = 0; m_data = '0;
        end else begin
            was_idle = !m_run;
            if (m_run) begin
                m_t++;
                if (m_t == m_end) begin
                    m_run = 0;
                    if (m_valid && m_rd) m_data = phy_resp;
                end
            end
            if (reg_wr && was_idle) begin
                if (!reg_addr) begin
                    if (reg_wdata[0]) begin
                        m_run   = 1;
                        m_t     = 1;
                        m_valid = reg_wdata[1];
                        m_rd    = reg_wdata[2];
                        m_n     = ratio_of(int'(reg_wdata[5:3]));
                        m_end   = m_valid ? 2 + 64 * m_n : 2;
                        m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01),
                                   reg_wdata[15:11], reg_wdata[10:6],
                                   (m_rd ? 2'b00 : 2'b10), (m_rd ? 16'h0 : m_data)};
                    end
                end else begin
                    m_data = reg_wdata;
                end
            end
        end
    end

    // Per-cycle comparison, then PHY response drive
    always @(negedge clk) begin
        if (!rst) begin
            bit e_mdc, e_oe, e_o;
            int k, b;
            e_mdc = 0; e_oe = 0; e_o = 0; b = 0;
            if (m_run && m_valid && m_t >= 2) begin
                k = m_t - 2;
                b = k / m_n;
                e_mdc = (k % m_n) >= (m_n / 2);
                e_oe  = !(m_rd && b >= 46);
                e_o   = m_frame[63 - b];
            end
            chk(m_run ? "R7 mdc period" : "R8 mdc idle", {31'b0, mdc}, {31'b0, e_mdc});
            chk(m_run ? "R4 output enable" : "R8 oe idle", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk("R3 R5 frame bit", {31'b0, mdio_o}, {31'b0, e_o});
            if (!reg_addr) chk("R2 busy bit", {31'b0, reg_rdata[0]}, {31'b0, m_run});
            if (m_run && m_valid && m_rd && m_t >= 2 && b >= 48)
                mdio_in <= phy_resp[15 - (b - 48)];
            else
                mdio_in <= 1'b1;
        end
    end

    task automatic wr(input logic a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        @(posedge clk); #1;
        reg_addr = a; #1;
        d = reg_rdata;
        reg_addr = 1'b0;
    endtask

    function automatic logic [15:0] cmd(input logic [4:0] phy, input logic [4:0] ra,
                                        input logic [2:0] cr, input logic r,
                                        input logic v, input logic g);
        return {phy, ra, cr, r, v, g};
    endfunction

    task automatic wait_idle();
        while (m_run) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #1_500_000;
        n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(1'b0, v); chk("R1 cmd reset", {16'b0, v}, 32'h0);
        rd(1'b1, v); chk("R1 data reset", {16'b0, v}, 32'h0);
        chk("R1 mdc reset", {31'b0, mdc}, 32'h0);
        chk("R1 oe reset", {31'b0, mdio_oe}, 32'h0);

        // R1: fields latched without start, no frame
        wr(1'b0, cmd(5'h03, 5'h07, 3'd1, 1'b1, 1'b1, 1'b0));
        rd(1'b0, v); chk("R1 cmd readback", {16'b0, v}, {16'b0, cmd(5'h03, 5'h07, 3'd1, 1'b1, 1'b1, 1'b0)});

        // R2 R3 R4 R7: write at code 2
        wr(1'b1, 16'hA5C3);
        wr(1'b0, cmd(5'h11, 5'h0A, 3'd2, 1'b0, 1'b1, 1'b1));
        wait_idle();
        rd(1'b0, v); chk("R1 R2 cmd after write", {16'b0, v}, {16'b0, cmd(5'h11, 5'h0A, 3'd2, 1'b0, 1'b1, 1'b0)});

        // R6: read at code 0
        phy_resp = 16'h3C96;
        wr(1'b0, cmd(5'h05, 5'h1F, 3'd0, 1'b1, 1'b1, 1'b1));
        wait_idle();
        rd(1'b1, v); chk("R6 read word", {16'b0, v}, 32'h3C96);

        // R9: writes during a read frame at code 3
        phy_resp = 16'h81E7;
        wr(1'b0, cmd(5'h1A, 5'h02, 3'd3, 1'b1, 1'b1, 1'b1));
        repeat (40) @(posedge clk);
        wr(1'b1, 16'hFFFF);
        wr(1'b0, cmd(5'h00, 5'h00, 3'd5, 1'b0, 1'b1, 1'b1));
        rd(1'b0, v); chk("R9 only range changes", {16'b0, v}, {16'b0, cmd(5'h1A, 5'h02, 3'd5, 1'b1, 1'b1, 1'b1)});
        wait_idle();
        rd(1'b1, v); chk("R9 R6 data kept for read", {16'b0, v}, 32'h81E7);

        // R10: invalid operation code
        wr(1'b0, cmd(5'h09, 5'h04, 3'd2, 1'b0, 1'b0, 1'b1));
        rd(1'b0, v); chk("R10 busy cleared", {31'b0, v[0]}, 32'h0);
        repeat (40) @(posedge clk);
        chk("R10 no clock", {31'b0, mdc}, 32'h0);

        // R7: code 4 and default code 7
        wr(1'b1, 16'h0F0F);
        wr(1'b0, cmd(5'h1F, 5'h15, 3'd4, 1'b0, 1'b1, 1'b1));
        wait_idle();
        phy_resp = 16'h5AA5;
        wr(1'b0, cmd(5'h0E, 5'h11, 3'd7, 1'b1, 1'b1, 1'b1));
        wait_idle();
        rd(1'b1, v); chk("R6 R7 read at default code", {16'b0, v}, 32'h5AA5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule